// File: doc/BRIEF.md
# Requester-ID to Stream-ID Mapping Table

This block translates the 16-bit requester ID carried by an upstream PCIe request into the stream ID that an IOMMU uses to pick a translation context. It holds a small table that software programs. Each table slot is one 32-bit word with three fields:

- a valid flag in bit 31;
- a 15-bit stream ID in bits 30:16;
- a requester ID in bits 15:0. The requester ID is laid out as bus in 15:8, device in 7:3 and function in 2:0.

The slot address space has room for up to 64 slots, but only `NUM_ENTRIES` of them are built. Slots past that count read as zero and drop writes. Software can therefore find the table size by writing a test pattern to each slot and reading it back.

The lookup side takes a requester ID with a strobe. Every valid entry is compared against it in parallel. One cycle later the block returns a result strobe, a hit flag and the stream ID. When several entries match, the lowest-numbered slot supplies the stream ID. A lookup that matches no valid entry raises a one-cycle map-error pulse, which is meant to feed an interrupt status bit. Writing zero to a slot invalidates it.

Top module: `rid_sid_map`

## Requirements
- R1: After a synchronous reset, every implemented slot reads as 0 and `res_valid`, `res_hit`, `res_sid` and `map_err` are 0.
- R2: A write to an implemented slot stores all 32 bits. A read of that slot in the cycle after the write returns the written word unchanged.
- R3: For a slot index at or above `NUM_ENTRIES`, a read returns 0 and a write changes no table state. Such a write can therefore neither create nor alter a lookup hit.
- R4: When `lk_valid` is high at a clock edge and some valid entry holds a requester ID equal to `lk_rid`, the outputs after that edge are `res_valid`=1, `res_hit`=1, and `res_sid` equal to that entry's bits 30:16.
- R5: When a looked-up requester ID matches no valid entry, the outputs after that edge are `res_valid`=1, `res_hit`=0, `res_sid`=0 and `map_err`=1, and `map_err` lasts only that cycle.
- R6: When several valid entries hold the looked-up requester ID, the stream ID comes from the lowest-numbered of them.
- R7: An entry whose bit 31 is 0 never matches, even when its bits 15:0 equal the key. Writing 0 to a slot removes it from lookups.
- R8: A lookup compares against the table as it stood before any write in the same cycle. That write is seen from the following lookup on.
- R9: In a cycle after an edge where `lk_valid` was low, `res_valid`, `res_hit` and `map_err` are 0.
- R10: Matching compares all 16 requester-ID bits. A key that differs from a stored requester ID only in the function bits (2:0) misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Slot write enable |
| cfg_wr_slot | input | SLOT_W | Slot index for the write |
| cfg_wdata | input | 32 | Word to write (valid in 31, stream ID in 30:16, requester ID in 15:0) |
| cfg_rd_slot | input | SLOT_W | Slot index to read |
| cfg_rdata | output | 32 | Contents of the selected slot, 0 for unimplemented slots |
| lk_valid | input | 1 | Lookup strobe |
| lk_rid | input | 16 | Requester ID to look up |
| res_valid | output | 1 | Lookup result strobe, one cycle after `lk_valid` |
| res_hit | output | 1 | Result matched a valid entry |
| res_sid | output | 15 | Stream ID of the winning entry, 0 on a miss |
| map_err | output | 1 | One-cycle pulse for a lookup that missed |

## Verification
The assertions assume a few things about the inputs:

- `lk_valid` is a clean synchronous level, and its result is not awaited before the next clock edge.
- Software is free to store duplicate requester IDs.
- The read slot index may point anywhere in the slot space, including past `NUM_ENTRIES`.

The stimulus stays within these assumptions:

- It drives every input at the falling edge only.
- It keeps lookups and slot writes within one cycle of each other only where a requirement asks for that overlap.
- It deliberately programs duplicate and invalid entries, so that the priority and valid-flag properties are actually exercised.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  localparam int RID_W  = 16;
  localparam int SID_W  = 15;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic             vld;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
  } rsm_entry_t;

  function automatic rsm_entry_t word_to_entry(input logic [WORD_W-1:0] w);
    rsm_entry_t e;
    e.vld = w[31];
    e.sid = w[30:16];
    e.rid = w[15:0];
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] entry_to_word(input rsm_entry_t e);
    return {e.vld, e.sid, e.rid};
  endfunction

  function automatic logic [RID_W-1:0] make_rid(input logic [7:0] bus,
                                                 input logic [4:0] dev,
                                                 input logic [2:0] fn);
    return {bus, dev, fn};
  endfunction

  function automatic logic entry_matches(input rsm_entry_t e,
                                         input logic [RID_W-1:0] key);
    return e.vld && (e.rid == key);
  endfunction

endpackage

// File: rtl/rsm_entry_bank.sv
module rsm_entry_bank
  import rsm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SLOT_W      = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [SLOT_W-1:0]   rd_slot,
  output logic [WORD_W-1:0]   rd_data,
  output rsm_entry_t          entries [NUM_ENTRIES]
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        entries[g] <= '0;
      end else if (sel) begin
        entries[g] <= word_to_entry(wr_data);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (rd_slot == SLOT_W'(i)) rd_data = entry_to_word(entries[i]);
    end
  end

endmodule

// File: rtl/rsm_match.sv
module rsm_match
  import rsm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  rsm_entry_t          entries [NUM_ENTRIES],
  input  logic [RID_W-1:0]    key,
  output logic [NUM_ENTRIES-1:0] match_vec,
  output logic [NUM_ENTRIES-1:0] win_vec,
  output logic                any_hit,
  output logic [SID_W-1:0]    win_sid
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = entry_matches(entries[g], key);
  end

  // isolate lowest set bit: lowest index has priority
  assign win_vec = match_vec & (~match_vec + NUM_ENTRIES'(1));
  assign any_hit = |match_vec;

  always_comb begin
    win_sid = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      win_sid = win_sid | ({SID_W{win_vec[i]}} & entries[i].sid);
    end
  end

endmodule

// File: rtl/rsm_result_reg.sv
module rsm_result_reg
  import rsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             any_hit,
  input  logic [SID_W-1:0] win_sid,
  output logic             res_valid,
  output logic             res_hit,
  output logic [SID_W-1:0] res_sid,
  output logic             map_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_sid   <= '0;
      map_err   <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_hit;
      res_sid   <= (lk_valid && any_hit) ? win_sid : '0;
      map_err   <= lk_valid && !any_hit;
    end
  end

endmodule

// File: rtl/rid_sid_map.sv
module rid_sid_map
  import rsm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SLOT_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_wr_slot,
  input  logic [31:0]       cfg_wdata,
  input  logic [SLOT_W-1:0] cfg_rd_slot,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_valid,
  input  logic [15:0]       lk_rid,
  output logic              res_valid,
  output logic              res_hit,
  output logic [14:0]       res_sid,
  output logic              map_err
);

  localparam int SLOT_SPACE = 1 << SLOT_W;

  initial begin
    if (NUM_ENTRIES < 1 || NUM_ENTRIES > SLOT_SPACE)
      $error("NUM_ENTRIES must fit the slot space");
  end

  rsm_entry_t                 entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]     match_vec;
  logic [NUM_ENTRIES-1:0]     win_vec;
  logic [NUM_ENTRIES-1:0]     valid_vec;
  logic                       any_hit;
  logic [SID_W-1:0]           win_sid;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = entries[g].vld;
  end

  rsm_entry_bank #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .SLOT_W     (SLOT_W)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_slot(cfg_wr_slot),
    .wr_data(cfg_wdata),
    .rd_slot(cfg_rd_slot),
    .rd_data(cfg_rdata),
    .entries(entries)
  );

  rsm_match #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_match (
    .entries  (entries),
    .key      (lk_rid),
    .match_vec(match_vec),
    .win_vec  (win_vec),
    .any_hit  (any_hit),
    .win_sid  (win_sid)
  );

  rsm_result_reg u_res (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .any_hit  (any_hit),
    .win_sid  (win_sid),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_sid  (res_sid),
    .map_err  (map_err)
  );

endmodule

// File: rtl/rid_sid_map_chk.sv
module rid_sid_map_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int SLOT_W      = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic [SLOT_W-1:0]      cfg_rd_slot,
  input logic [31:0]            cfg_rdata,
  input logic                   lk_valid,
  input logic                   res_valid,
  input logic                   res_hit,
  input logic [14:0]            res_sid,
  input logic                   map_err,
  input logic [NUM_ENTRIES-1:0] match_vec,
  input logic [NUM_ENTRIES-1:0] win_vec,
  input logic [NUM_ENTRIES-1:0] valid_vec
);

  // R4
  strobe_to_result_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && !res_hit && !map_err));

  // R4
  hit_when_match_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (|match_vec)) |=> res_hit);

  // R5
  err_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    map_err |-> (res_valid && !res_hit));

  // R5
  miss_raises_err_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> map_err);

  // R5
  sid_zero_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_sid == '0));

  // R6
  single_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_vec));

  // R7
  winner_is_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (win_vec & ~valid_vec) == '0);

  // R3
  unimpl_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cfg_rd_slot} >= (SLOT_W+1)'(NUM_ENTRIES)) |-> (cfg_rdata == '0));

endmodule

bind rid_sid_map rid_sid_map_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .SLOT_W     (SLOT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_rd_slot(cfg_rd_slot),
  .cfg_rdata  (cfg_rdata),
  .lk_valid   (lk_valid),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_sid    (res_sid),
  .map_err    (map_err),
  .match_vec  (match_vec),
  .win_vec    (win_vec),
  .valid_vec  (valid_vec)
);

// File: tb/rid_sid_map_tb.sv
module rid_sid_map_tb;

  localparam int N  = 16;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_wr_slot = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [SW-1:0] cfg_rd_slot = '0;
  logic [31:0]   cfg_rdata;
  logic          lk_valid = 1'b0;
  logic [15:0]   lk_rid = '0;
  logic          res_valid, res_hit, map_err;
  logic [14:0]   res_sid;

  always #2.5 clk = ~clk;

  rid_sid_map #(.NUM_ENTRIES(N), .SLOT_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wr_slot(cfg_wr_slot),
    .cfg_wdata(cfg_wdata), .cfg_rd_slot(cfg_rd_slot), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_rid(lk_rid), .res_valid(res_valid),
    .res_hit(res_hit), .res_sid(res_sid), .map_err(map_err)
  );

  typedef struct {
    logic        hit;
    logic [14:0] sid;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_word(input bit v, input logic [14:0] sid,
                                          input logic [15:0] rid);
    return (v ? 32'h8000_0000 : 32'h0) | (32'(sid) << 16) | 32'(rid);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int slot, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wr_slot = SW'(slot); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int slot, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd_slot = SW'(slot);
    #1;
    check(cfg_rdata == exp, tag, "readback", cfg_rdata, exp);
  endtask

  task automatic push(input logic hit, input logic [14:0] sid, input string tag);
    exp_t e;
    e.hit = hit; e.sid = sid; e.cyc = cyc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // one lookup strobe, leaves lk_valid high until the next negedge action
  task automatic look(input logic [15:0] rid, input logic hit,
                      input logic [14:0] sid, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_rid = rid;
    push(hit, sid, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_valid = 1'b0;
    end
  endtask

  // monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected result", 32'(res_valid), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.cyc + 1, "R4", "latency", 32'(cyc - e.cyc), 32'h1);
          check(res_hit == e.hit, e.tag, "hit", 32'(res_hit), 32'(e.hit));
          check(res_sid == e.sid, e.tag, "sid", 32'(res_sid), 32'(e.sid));
          check(map_err == !e.hit, "R5", "map_err", 32'(map_err), 32'(!e.hit));
        end
      end else begin
        if (map_err || res_hit)
          check(1'b0, "R9", "flags while idle", {30'h0, map_err, res_hit}, 32'h0);
        if (exp_q.size() != 0 && cyc > exp_q[0].cyc + 1)
          check(1'b0, exp_q[0].tag, "missing result", 32'h0, 32'h1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk(0, 32'h0, "R1");
    rd_chk(N-1, 32'h0, "R1");
    check(!res_valid && !res_hit && !map_err && res_sid == 0, "R1", "outputs",
          {28'h0, res_valid, res_hit, map_err, |res_sid}, 32'h0);

    // R3 probe: unimplemented slot drops write, last implemented keeps it
    wr(N, 32'h000b_ad1d);
    rd_chk(N, 32'h0, "R3");
    wr(N-1, 32'h000b_ad1d);
    rd_chk(N-1, 32'h000b_ad1d, "R2");
    wr(63, mk_word(1, 15'h0abc, 16'h0777));
    rd_chk(63, 32'h0, "R3");

    // program table (bus 15:8, dev 7:3, fn 2:0)
    wr(3, mk_word(1, 15'h1234, {8'h02, 5'd5, 3'd1}));
    wr(7, mk_word(1, 15'h0055, {8'h02, 5'd5, 3'd1}));
    wr(9, mk_word(1, 15'h7fff, 16'h0100));
    wr(2, mk_word(0, 15'h0005, 16'h0300));
    wr(0, mk_word(1, 15'h0022, 16'h0000));
    wr(N-1, mk_word(1, 15'h0001, 16'hffff));
    rd_chk(3, 32'h9234_0229, "R2");
    rd_chk(2, 32'h0005_0300, "R2");

    // lookups, back to back
    look(16'h0229, 1'b1, 15'h1234, "R6");
    look(16'h022a, 1'b0, 15'h0,    "R10");
    look(16'h0100, 1'b1, 15'h7fff, "R4");
    look(16'h0300, 1'b0, 15'h0,    "R7");
    look(16'h0000, 1'b1, 15'h0022, "R4");
    look(16'hffff, 1'b1, 15'h0001, "R4");
    look(16'h0777, 1'b0, 15'h0,    "R3");
    idle(3);

    // R7 invalidate by writing zero; duplicate at slot 7 takes over
    wr(3, 32'h0);
    rd_chk(3, 32'h0, "R7");
    look(16'h0229, 1'b1, 15'h0055, "R7");
    idle(2);

    // R8 write in the same cycle as a lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_wr_slot = SW'(9); cfg_wdata = 32'h0;
    lk_valid = 1'b1; lk_rid = 16'h0100;
    push(1'b1, 15'h7fff, "R8");
    @(negedge clk);
    cfg_we = 1'b0;
    lk_valid = 1'b1; lk_rid = 16'h0100;
    push(1'b0, 15'h0, "R8");
    idle(3);

    // R5 map_err is a single-cycle pulse
    look(16'h4242, 1'b0, 15'h0, "R5");
    idle(1);
    @(negedge clk);
    check(!map_err, "R5", "pulse width", 32'(map_err), 32'h0);
    idle(3);

    check(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule